// File: doc/BRIEF.md
# Egress Port Set Resolver

This block decides where a classified frame may go inside a small switch. It takes one descriptor per frame: the ingress port, whether the frame carried a VLAN tag, the VID from that tag, the candidate egress set produced by the destination lookup (a single port for a known unicast address, a wider set for flooding), and a trap flag for management frames. It returns one egress port bitmap and one drop flag per descriptor. Descriptors come in and results go out through valid/ready handshakes.

Two configuration sets restrict forwarding. The first is a reachability mask for each ingress port, which keeps separate bridges apart. The second is a membership table indexed by VID, which restricts forwarding inside a bridge. A third per-port setting is the default VID, given to untagged frames. A frame whose ingress port does not belong to its VLAN is dropped at ingress. Otherwise the result is the AND of the reachability mask, the membership set and the candidate set. Trapped frames skip the VLAN and bridge rules and go to the host port only. All configuration is written through a single address/data write port.

Top module: `fwd_mask_resolver`

## Requirements
- R1: An untagged descriptor (`in_tagged`=0) is resolved with the default VID of its ingress port. A tagged descriptor is resolved with `in_vid`.
- R2: When the ingress port is not a member of the resolved VLAN and the frame is not trapped, the result is drop=1 with an all-zero mask.
- R3: For a non-trapped frame from a member port, the mask is reach[ingress] AND members[VID] AND `in_fwd_mask`, with the ingress bit cleared. The same rule applies to single-port and flood candidate sets.
- R4: A trapped descriptor (`in_trap`=1) yields a mask holding only the host port bit (HOST_PORT, default 5). VLAN membership, reachability and `in_fwd_mask` do not affect it.
- R5: The ingress port's own bit is never set in the result. A trap from the host port therefore yields drop=1.
- R6: A VLAN table entry that has never been written has no members.
- R7: When the mask is all zero after masking, the result is drop=1 and mask=0. A result with drop=0 always has at least one bit set.
- R8: Exactly one result is produced per accepted descriptor, one cycle after acceptance. `in_ready` equals `!out_valid || out_ready`. While `out_valid`=1 and `out_ready`=0, the mask and drop outputs hold.
- R9: After reset, `out_valid`=0, every VLAN entry is unwritten, every reachability mask is zero and every default VID is zero.
- R10: A write with `cfg_we`=1 is selected by `cfg_target`. Code 0 writes the VLAN entry at address VID with members in `cfg_data[NUM_PORTS-1:0]`. Code 1 writes the reachability mask of port `cfg_addr`. Code 2 writes the default VID of port `cfg_addr` from `cfg_data`. Code 3, or a port address of NUM_PORTS or more, changes nothing. A write takes effect for descriptors accepted in later cycles, not for one accepted in the same cycle.
- R11: A descriptor whose ingress port number is NUM_PORTS or more yields drop=1 with mask 0, even when it is trapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_target | input | 2 | Write target: 0 VLAN entry, 1 reachability, 2 default VID, 3 none |
| cfg_addr | input | VID_W (12) | VID for target 0, port number for targets 1 and 2 |
| cfg_data | input | VID_W (12) | Member bitmap, reachability mask or default VID |
| in_valid | input | 1 | Descriptor valid |
| in_ready | output | 1 | Descriptor accepted when high together with in_valid |
| in_port | input | PORT_W (3) | Ingress port number |
| in_tagged | input | 1 | Frame carried a VLAN tag |
| in_vid | input | VID_W (12) | VID decoded from the tag |
| in_fwd_mask | input | NUM_PORTS (6) | Candidate egress set from the destination lookup |
| in_trap | input | 1 | Management frame to be trapped to the host |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result consumer ready |
| out_mask | output | NUM_PORTS (6) | Egress port bitmap |
| out_drop | output | 1 | Frame is dropped |

## Verification
The stimulus uses two bridges that share the host port, along with VLANs of full, partial and no membership. This separates the reachability term from the membership term, because each one removes ports that the other keeps. Single-port candidates are run against flood candidates to show that the AND applies to both. Tagged and untagged frames from the same port show which VID the lookup used. Traps on unwritten VLANs, traps from the host port, out-of-range ports and same-cycle configuration writes each test one bypass or ordering rule. A randomized run with random backpressure, compared cycle by cycle against a behavioural model, covers the handshake holding rule.

// File: rtl/fwd_resolver_pkg.sv
// Shared definitions for the egress port set resolver.
// Assumes nothing beyond a 2-bit configuration target code.
package fwd_resolver_pkg;

    // Configuration write targets, as seen on cfg_target.
    typedef enum logic [1:0] {
        CFG_VLAN  = 2'd0,
        CFG_REACH = 2'd1,
        CFG_PVID  = 2'd2,
        CFG_NONE  = 2'd3
    } cfg_target_e;

endpackage

// File: rtl/fwd_vlan_table.sv
// VLAN membership table: one member bitmap per VID.
// The storage itself has no reset. A written-flag per entry (reset to zero)
// makes any entry that has not been written read back as "no members".
// The read is combinational; a write is visible from the next cycle.
module fwd_vlan_table #(
    parameter int NUM_PORTS = 6,
    parameter int VID_W     = 12,
    localparam int DEPTH    = 1 << VID_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [VID_W-1:0]     wr_vid,
    input  logic [NUM_PORTS-1:0] wr_members,
    input  logic [VID_W-1:0]     rd_vid,
    output logic [NUM_PORTS-1:0] rd_members
);

    logic [NUM_PORTS-1:0] mem_q [DEPTH];
    logic [DEPTH-1:0]     written_q;

    // Store the member bitmap of the addressed VID.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_vid] <= wr_members;
        end
    end

    // Track which entries hold a real value; reset marks them all empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            written_q <= '0;
        end else if (wr_en) begin
            written_q[wr_vid] <= 1'b1;
        end
    end

    // Return the members, or an empty set for an unwritten entry.
    always_comb begin
        rd_members = written_q[rd_vid] ? mem_q[rd_vid] : '0;
    end

endmodule

// File: rtl/fwd_port_cfg.sv
// Per-port configuration: the bridge reachability mask and the default VID.
// One register set is built per port. Reset clears both to zero.
// A write to a port number of NUM_PORTS or above matches no set.
module fwd_port_cfg #(
    parameter int NUM_PORTS = 6,
    parameter int VID_W     = 12,
    localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reach_we,
    input  logic                 pvid_we,
    input  logic [VID_W-1:0]     wr_addr,
    input  logic [VID_W-1:0]     wr_data,
    input  logic [PORT_W-1:0]    rd_port,
    output logic [NUM_PORTS-1:0] rd_reach,
    output logic [VID_W-1:0]     rd_pvid
);

    logic [NUM_PORTS-1:0][NUM_PORTS-1:0] reach_all;
    logic [NUM_PORTS-1:0][VID_W-1:0]     pvid_all;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic [NUM_PORTS-1:0] reach_q;
        logic [VID_W-1:0]     pvid_q;
        logic                 hit;

        assign hit = (wr_addr == VID_W'(p));

        // Hold this port's reachability mask and default VID.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                reach_q <= '0;
                pvid_q  <= '0;
            end else begin
                if (reach_we && hit) reach_q <= wr_data[NUM_PORTS-1:0];
                if (pvid_we && hit)  pvid_q  <= wr_data;
            end
        end

        assign reach_all[p] = reach_q;
        assign pvid_all[p]  = pvid_q;
    end

    // Select the settings of the port being read (the caller keeps it in range).
    always_comb begin
        rd_reach = reach_all[rd_port];
        rd_pvid  = pvid_all[rd_port];
    end

endmodule

// File: rtl/fwd_mask_calc.sv
// Combinational egress decision for one descriptor.
// Assumes the members and reach inputs already belong to the descriptor's
// VID and ingress port. Order: invalid port, then trap, then membership,
// then the AND of the three sets. The ingress bit is always removed.
module fwd_mask_calc #(
    parameter int NUM_PORTS = 6,
    parameter int HOST_PORT = 5,
    localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                 port_ok,
    input  logic [PORT_W-1:0]    in_port,
    input  logic                 trap,
    input  logic [NUM_PORTS-1:0] members,
    input  logic [NUM_PORTS-1:0] reach,
    input  logic [NUM_PORTS-1:0] fwd,
    output logic [NUM_PORTS-1:0] res_mask,
    output logic                 res_drop
);

    logic [NUM_PORTS-1:0] host_bit;
    logic [NUM_PORTS-1:0] ingress_bit;
    logic [NUM_PORTS-1:0] cand;

    // Build the one-hot host and ingress vectors.
    always_comb begin
        host_bit              = '0;
        host_bit[HOST_PORT]   = 1'b1;
        ingress_bit           = '0;
        if (port_ok) ingress_bit[in_port] = 1'b1;
    end

    // Apply the rules in priority order.
    always_comb begin
        if (!port_ok) begin
            cand = '0;
        end else if (trap) begin
            cand = host_bit & ~ingress_bit;
        end else if (!members[in_port]) begin
            cand = '0;
        end else begin
            cand = reach & members & fwd & ~ingress_bit;
        end
    end

    // An empty set becomes a drop.
    always_comb begin
        res_drop = (cand == '0);
        res_mask = cand;
    end

endmodule

// File: rtl/fwd_mask_resolver.sv
// Egress port set resolver top.
// Accepts one descriptor per cycle when in_ready is high. It resolves the VID,
// reads the per-port and per-VLAN configuration, and registers the result in
// one output stage. in_ready = !out_valid || out_ready. Assumes
// HOST_PORT < NUM_PORTS and NUM_PORTS <= VID_W.
module fwd_mask_resolver #(
    parameter int NUM_PORTS = 6,
    parameter int HOST_PORT = 5,
    parameter int VID_W     = 12,
    localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [1:0]           cfg_target,
    input  logic [VID_W-1:0]     cfg_addr,
    input  logic [VID_W-1:0]     cfg_data,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [PORT_W-1:0]    in_port,
    input  logic                 in_tagged,
    input  logic [VID_W-1:0]     in_vid,
    input  logic [NUM_PORTS-1:0] in_fwd_mask,
    input  logic                 in_trap,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [NUM_PORTS-1:0] out_mask,
    output logic                 out_drop
);
    import fwd_resolver_pkg::*;

    logic                 port_ok;
    logic [PORT_W-1:0]    sel_port;
    logic [NUM_PORTS-1:0] port_reach;
    logic [VID_W-1:0]     port_pvid;
    logic [VID_W-1:0]     eff_vid;
    logic [NUM_PORTS-1:0] vlan_members;
    logic [NUM_PORTS-1:0] res_mask;
    logic                 res_drop;
    logic                 vlan_we;
    logic                 reach_we;
    logic                 pvid_we;
    logic                 accept;

    // Decode the configuration target.
    always_comb begin
        vlan_we  = cfg_we && (cfg_target_e'(cfg_target) == CFG_VLAN);
        reach_we = cfg_we && (cfg_target_e'(cfg_target) == CFG_REACH);
        pvid_we  = cfg_we && (cfg_target_e'(cfg_target) == CFG_PVID);
    end

    // Range-check the ingress port and keep the read index safe.
    always_comb begin
        port_ok  = ({1'b0, in_port} < (PORT_W + 1)'(NUM_PORTS));
        sel_port = port_ok ? in_port : '0;
    end

    fwd_port_cfg #(
        .NUM_PORTS (NUM_PORTS),
        .VID_W     (VID_W)
    ) port_cfg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .reach_we (reach_we),
        .pvid_we  (pvid_we),
        .wr_addr  (cfg_addr),
        .wr_data  (cfg_data),
        .rd_port  (sel_port),
        .rd_reach (port_reach),
        .rd_pvid  (port_pvid)
    );

    // Untagged frames take the port default VID.
    always_comb begin
        eff_vid = in_tagged ? in_vid : port_pvid;
    end

    fwd_vlan_table #(
        .NUM_PORTS (NUM_PORTS),
        .VID_W     (VID_W)
    ) vlan_tbl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (vlan_we),
        .wr_vid     (cfg_addr),
        .wr_members (cfg_data[NUM_PORTS-1:0]),
        .rd_vid     (eff_vid),
        .rd_members (vlan_members)
    );

    fwd_mask_calc #(
        .NUM_PORTS (NUM_PORTS),
        .HOST_PORT (HOST_PORT)
    ) calc_i (
        .port_ok  (port_ok),
        .in_port  (sel_port),
        .trap     (in_trap),
        .members  (vlan_members),
        .reach    (port_reach),
        .fwd      (in_fwd_mask),
        .res_mask (res_mask),
        .res_drop (res_drop)
    );

    // Accept a descriptor when the output stage is empty or draining.
    always_comb begin
        in_ready = !out_valid || out_ready;
        accept   = in_valid && in_ready;
    end

    // Output register: load on accept, clear when drained, hold when stalled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_mask  <= '0;
            out_drop  <= 1'b0;
        end else if (in_ready) begin
            out_valid <= in_valid;
            if (accept) begin
                out_mask <= res_mask;
                out_drop <= res_drop;
            end
        end
    end

endmodule

// File: rtl/fwd_mask_resolver_chk.sv
// Property checker for the egress port set resolver, bound to the top.
// It keeps its own copy of the accepted descriptor fields so that each
// result can be checked against the descriptor that produced it.
module fwd_mask_resolver_chk #(
    parameter int NUM_PORTS = 6,
    parameter int HOST_PORT = 5,
    localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 in_ready,
    input logic [PORT_W-1:0]    in_port,
    input logic [NUM_PORTS-1:0] in_fwd_mask,
    input logic                 in_trap,
    input logic                 out_valid,
    input logic                 out_ready,
    input logic [NUM_PORTS-1:0] out_mask,
    input logic                 out_drop
);

    logic [PORT_W-1:0]    cap_port;
    logic                 cap_ok;
    logic                 cap_trap;
    logic [NUM_PORTS-1:0] cap_fwd;
    logic [NUM_PORTS-1:0] host_only;

    always_comb begin
        host_only            = '0;
        host_only[HOST_PORT] = 1'b1;
    end

    // Record the fields of each accepted descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_port <= '0;
            cap_ok   <= 1'b0;
            cap_trap <= 1'b0;
            cap_fwd  <= '0;
        end else if (in_valid && in_ready) begin
            cap_port <= in_port;
            cap_ok   <= ({1'b0, in_port} < (PORT_W + 1)'(NUM_PORTS));
            cap_trap <= in_trap;
            cap_fwd  <= in_fwd_mask;
        end
    end

    a_r3_within_candidates: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !cap_trap) |-> ((out_mask & ~cap_fwd) == '0));

    a_r4_trap_host_only: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cap_trap) |-> ((out_mask & ~host_only) == '0));

    a_r5_no_hairpin: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cap_ok) |-> !out_mask[cap_port]);

    a_r7_drop_means_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_drop) |-> (out_mask == '0));

    a_r7_forward_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_drop) |-> (out_mask != '0));

    a_r8_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_mask) && $stable(out_drop)));

    a_r8_ready_rule: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready == (!out_valid || out_ready));

    a_r11_bad_port_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !cap_ok) |-> out_drop);

endmodule

bind fwd_mask_resolver fwd_mask_resolver_chk #(
    .NUM_PORTS (NUM_PORTS),
    .HOST_PORT (HOST_PORT)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_port     (in_port),
    .in_fwd_mask (in_fwd_mask),
    .in_trap     (in_trap),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_mask    (out_mask),
    .out_drop    (out_drop)
);

// File: tb/fwd_mask_resolver_tb_top.sv
`timescale 1ns/1ps
// Bench for the egress port set resolver. A behavioural model runs alongside
// the design and is compared with it on every clock.
module fwd_mask_resolver_tb_top;
    localparam int NP   = 6;
    localparam int HOST = 5;
    localparam int VW   = 12;
    localparam int PW   = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_target = 2'd3;
    logic [VW-1:0] cfg_addr = '0;
    logic [VW-1:0] cfg_data = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [PW-1:0] in_port = '0;
    logic          in_tagged = 1'b0;
    logic [VW-1:0] in_vid = '0;
    logic [NP-1:0] in_fwd_mask = '0;
    logic          in_trap = 1'b0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [NP-1:0] out_mask;
    logic          out_drop;

    always #2 clk = ~clk;

    fwd_mask_resolver #(.NUM_PORTS(NP), .HOST_PORT(HOST), .VID_W(VW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_target(cfg_target),
        .cfg_addr(cfg_addr), .cfg_data(cfg_data), .in_valid(in_valid),
        .in_ready(in_ready), .in_port(in_port), .in_tagged(in_tagged),
        .in_vid(in_vid), .in_fwd_mask(in_fwd_mask), .in_trap(in_trap),
        .out_valid(out_valid), .out_ready(out_ready), .out_mask(out_mask),
        .out_drop(out_drop));

    int    total = 0;
    int    bad = 0;
    bit    done = 0;
    string req = "R9";

    // Behavioural model state
    bit [NP-1:0] m_reach [NP];
    bit [VW-1:0] m_pvid [NP];
    bit [NP-1:0] m_vlan [int];
    bit          m_valid = 0;
    bit [NP-1:0] m_mask = '0;
    bit          m_drop = 0;

    function automatic void m_resolve(output bit [NP-1:0] mk, output bit dr);
        int p = int'(in_port);
        int v;
        bit [NP-1:0] mem;
        bit [NP-1:0] r;
        mk = '0;
        if (p < NP) begin
            v = in_tagged ? int'(in_vid) : int'(m_pvid[p]);
            mem = m_vlan.exists(v) ? m_vlan[v] : '0;
            if (in_trap) begin
                if (p != HOST) mk[HOST] = 1'b1;
            end else if (mem[p]) begin
                r = m_reach[p] & mem & in_fwd_mask;
                r[p] = 1'b0;
                mk = r;
            end
        end
        dr = (mk == '0);
    endfunction

    task automatic check(input bit ok, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One clock: check ready, step model, pass the edge, compare outputs.
    task automatic tick();
        bit          rdy;
        bit          acc;
        bit [NP-1:0] mk;
        bit          dr;
        #1;
        rdy = !m_valid || out_ready;
        check(in_ready == rdy, "in_ready", int'(in_ready), int'(rdy));
        acc = in_valid && rdy;
        if (rdy) begin
            if (acc) begin
                m_resolve(mk, dr);
                m_mask = mk;
                m_drop = dr;
            end
            m_valid = acc;
        end
        if (cfg_we) begin
            if (cfg_target == 2'd0) m_vlan[int'(cfg_addr)] = cfg_data[NP-1:0];
            else if (cfg_target == 2'd1 && cfg_addr < NP) m_reach[int'(cfg_addr)] = cfg_data[NP-1:0];
            else if (cfg_target == 2'd2 && cfg_addr < NP) m_pvid[int'(cfg_addr)] = cfg_data;
        end
        @(posedge clk);
        #1;
        check(out_valid == m_valid, "out_valid", int'(out_valid), int'(m_valid));
        if (m_valid) begin
            check(out_mask == m_mask && out_drop == m_drop, "mask/drop",
                  int'({out_drop, out_mask}), int'({m_drop, m_mask}));
        end
        @(negedge clk);
        cfg_we = 1'b0;
        in_valid = 1'b0;
    endtask

    task automatic cfg(input int tgt, input int addr, input int data);
        cfg_we = 1'b1; cfg_target = 2'(tgt); cfg_addr = VW'(addr); cfg_data = VW'(data);
        tick();
    endtask

    task automatic send(input int p, input bit tg, input int vid, input int fwd, input bit tr);
        in_valid = 1'b1; in_port = PW'(p); in_tagged = tg; in_vid = VW'(vid);
        in_fwd_mask = NP'(fwd); in_trap = tr;
        tick();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        for (int i = 0; i < NP; i++) begin m_reach[i] = '0; m_pvid[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state
        #1;
        check(out_valid == 1'b0 && in_ready == 1'b1, "reset outputs",
              int'({out_valid, in_ready}), 1);
        // R9 R6: after reset the default VID is 0 and VLAN 0 is unwritten, so the frame drops
        req = "R6"; send(0, 0, 0, 'h3F, 0); tick();

        // Two bridges: {0,1} and {2,3,4}, with the host port reachable from both
        req = "R10";
        cfg(1, 0, 'h23); cfg(1, 1, 'h23);
        cfg(1, 2, 'h3C); cfg(1, 3, 'h3C); cfg(1, 4, 'h3C); cfg(1, 5, 'h3F);
        cfg(0, 10, 'h3F); cfg(0, 20, 'h25); cfg(2, 0, 10); cfg(2, 2, 20);
        // R10: code 3 and an out-of-range port address change nothing
        cfg(3, 1, 'h3F); cfg(1, 6, 'h3F); cfg(2, 7, 99);

        // R3: flood from port 0 on VLAN 10 is limited to bridge A
        req = "R3"; send(0, 0, 0, 'h3F, 0); tick();
        // R3: single-port candidate inside and outside the bridge
        send(1, 1, 10, 'h01, 0); send(1, 1, 10, 'h04, 0); tick();
        // R3: flood from bridge B
        send(3, 1, 10, 'h3F, 0); tick();
        // R1: untagged from port 2 uses VID 20; tagged uses VID 10
        req = "R1"; send(2, 0, 7, 'h3F, 0); send(2, 1, 10, 'h3F, 0); tick();
        // R2: port 1 is not a member of VLAN 20
        req = "R2"; send(1, 1, 20, 'h3F, 0); tick();
        // R6: an unwritten VID has no members
        req = "R6"; send(0, 1, 99, 'h3F, 0); tick();
        // R4: trap on an unwritten VLAN with an empty candidate set
        req = "R4"; send(1, 1, 99, 'h00, 0); send(1, 1, 99, 'h00, 1); tick();
        // R5: trap from the host port has nowhere to go
        req = "R5"; send(5, 1, 10, 'h3F, 1); send(5, 1, 10, 'h3F, 0); tick();
        // R7: every term allows forwarding, but the only candidate is the ingress port
        req = "R7"; send(0, 1, 10, 'h01, 0); tick();
        // R11: ingress port numbers out of range
        req = "R11"; send(6, 1, 10, 'h3F, 0); send(7, 1, 10, 'h3F, 1); tick();
        // R10: a write in the same cycle as acceptance applies only to later descriptors
        req = "R10";
        cfg_we = 1'b1; cfg_target = 2'd0; cfg_addr = VW'(30); cfg_data = VW'('h3F);
        send(0, 1, 30, 'h3F, 0);
        send(0, 1, 30, 'h3F, 0); tick();
        // R8: backpressure holds the result and blocks acceptance
        req = "R8";
        out_ready = 1'b0;
        send(0, 1, 10, 'h3F, 0); send(2, 1, 20, 'h3F, 0); send(3, 1, 10, 'h3F, 0);
        out_ready = 1'b1; tick(); tick();

        // R3: random traffic with random stalls and occasional writes
        req = "R3";
        for (int n = 0; n < 400; n++) begin
            int sel = $urandom_range(0, 3);
            out_ready = ($urandom_range(0, 3) != 0);
            if ($urandom_range(0, 9) == 0) begin
                cfg_we = 1'b1;
                cfg_target = 2'($urandom_range(0, 3));
                cfg_addr = (cfg_target == 2'd0) ? VW'(30) : VW'($urandom_range(0, 7));
                cfg_data = (cfg_target == 2'd2) ? VW'($urandom_range(0, 3) * 10)
                                                : VW'($urandom_range(0, 63));
            end
            in_valid = ($urandom_range(0, 3) != 0);
            in_port = PW'($urandom_range(0, 7));
            in_tagged = $urandom_range(0, 1) != 0;
            in_vid = (sel == 3) ? VW'(99) : VW'(10 * (sel + 1));
            in_fwd_mask = NP'($urandom_range(0, 63));
            in_trap = ($urandom_range(0, 7) == 0);
            tick();
        end
        out_ready = 1'b1; tick(); tick();
        finish_run();
    end
endmodule